// File: doc/BRIEF.md
# Quad-Precision Compare with Condition-Code Writeback

This block compares two 128-bit IEEE 754 binary128 operands, A and B. It produces a 2-bit relation of A to B and writes it into one of four floating-point condition-code fields of a 64-bit status word. The caller picks the field with a 2-bit selector. A mode bit chooses between a quiet compare and a signaling compare, and the two modes raise the invalid-operation flag under different NaN rules.

The caller presents both operands, their source register numbers, the current status word, the mode and the selector, and pulses `start` for one cycle. One cycle later `done` pulses, and `status_out` and `exc_flags` carry the result. The caller loads `status_out` back as its new status word. If a quad source register number is not legal, the block reports a register error in the trap-type field instead and writes no condition code. Trap decisions and accumulation of exception history belong to a downstream unit.

Top module: `qcmp_unit`

## Requirements
- R1: `done` is high in exactly the cycle after each cycle in which `start` is high. When `start` is low, `status_out` and `exc_flags` keep their values.
- R2: For ordered operands the relation of A to B is coded 0 equal, 1 less, 2 greater. The order follows the sign and then the 127-bit exponent/fraction magnitude. When both operands are negative, the magnitude order is reversed. Infinities order like any other value.
- R3: Positive zero and negative zero compare equal (code 0) in either order.
- R4: If either operand is a NaN (exponent bits 126:112 all ones, fraction bits 111:0 nonzero), the relation is unordered (code 3).
- R5: `exc_flags` bit 4 is the invalid flag, and bits 3:0 are always 0. In signaling mode (`signaling`=1), invalid is set whenever the relation is unordered.
- R6: In quiet mode, invalid is set only when an operand is a signaling NaN: a NaN whose fraction bit 111 is 0. A quiet NaN (bit 111 = 1) gives unordered with no flag. Ordered results never raise invalid.
- R7: The relation goes to `status_out` bits 11:10 for selector 0, 33:32 for 1, 35:34 for 2 and 37:36 for 3. Every other bit outside the trap-type field is copied from `status_in`.
- R8: A legal compare clears the trap-type field, `status_out` bits 16:14, to 0.
- R9: If bit 1 of either source register number is set, the compare is illegal. The trap-type field becomes 6, all other status bits are copied unchanged, no condition code is written and `exc_flags` is 0.
- R10: After reset, `status_out`, `exc_flags` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to compare |
| signaling | input | 1 | 1 = signaling compare, 0 = quiet compare |
| fcc_sel | input | 2 | Condition-code field to write |
| src_a_num | input | 5 | Register number of operand A |
| src_b_num | input | 5 | Register number of operand B |
| op_a | input | 128 | Operand A |
| op_b | input | 128 | Operand B |
| status_in | input | 64 | Current status word |
| status_out | output | 64 | Updated status word |
| exc_flags | output | 5 | Exception flags, bit 4 = invalid |
| done | output | 1 | Result valid pulse |

## Verification
The bench aims at the sign handling.
- Two negative operands catch a design that forgets to reverse the magnitude order; it would swap less and greater.
- Positive against negative zero catches a raw bit compare, which would call the two unequal.
- Quiet NaNs and signaling NaNs are applied in both modes. This catches an invalid flag raised on a quiet NaN in quiet mode, or one missed on an unordered signaling compare.
- Each selector value is run against an all-ones status word. A wrong field offset, or a clobbered neighbour field, shows up as a changed bit.
- An illegal register number on either source must leave the condition codes untouched and place 6 in the trap-type field.

// File: rtl/qcmp_pkg.sv
// Package: shared constants, relation codes and field-position helpers for
// the quad compare block. Assumes a 64-bit status word layout with the four
// condition-code fields and the trap-type field at fixed positions.
package qcmp_pkg;

    localparam int QW        = 128;
    localparam int EXP_W     = 15;
    localparam int FRAC_W    = QW - 1 - EXP_W;
    localparam int STAT_W    = 64;
    localparam int EXC_W     = 5;
    localparam int EXC_INV   = 4;
    localparam int FTT_LSB   = 14;
    localparam int FTT_W     = 3;
    localparam int NUM_FCC   = 4;
    localparam int REGNUM_W  = 5;
    localparam logic [FTT_W-1:0] FTT_BAD_REG = 3'd6;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    // Bit position of the low bit of condition-code field idx.
    function automatic int fcc_lsb(input int idx);
        case (idx)
            0:       return 10;
            1:       return 32;
            2:       return 34;
            default: return 36;
        endcase
    endfunction

endpackage

// File: rtl/qcmp_classify.sv
// Module: classifies one binary128 operand. Reports NaN, signaling NaN,
// zero of either sign, the sign bit and the magnitude (exponent+fraction).
// Assumes the quiet bit is the top fraction bit.
module qcmp_classify #(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 112,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int MAG_W = W - 1
) (
    input  logic [W-1:0]     op,
    output logic             is_nan,
    output logic             is_snan,
    output logic             is_zero,
    output logic             sign,
    output logic [MAG_W-1:0] mag
);

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    // Split the operand into its fields.
    always_comb begin
        sign = op[W-1];
        expo = op[W-2 -: EXP_W];
        frac = op[FRAC_W-1:0];
        mag  = op[MAG_W-1:0];
    end

    // Derive the class flags.
    always_comb begin
        is_nan  = (&expo) && (|frac);
        is_snan = is_nan && !frac[FRAC_W-1];
        is_zero = (mag == '0);
    end

endmodule

// File: rtl/qcmp_relate.sv
// Module: computes the 2-bit relation of A to B from classified operands.
// Internally forms +1 (A<B), 0 (equal) or -1 (A>B) and remaps -1 to the
// greater code. Assumes NaN detection is done by the classifier.
module qcmp_relate
    import qcmp_pkg::*;
#(
    parameter int MAG_W = 127
) (
    input  logic             nan_a,
    input  logic             nan_b,
    input  logic             zero_a,
    input  logic             zero_b,
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output rel_e             rel
);

    logic              mag_lt;
    logic              mag_eq;
    logic signed [1:0] ord;

    // Magnitude comparison shared by all sign cases.
    always_comb begin
        mag_lt = (mag_a < mag_b);
        mag_eq = (mag_a == mag_b);
    end

    // Signed ordering: +1 means A below B, -1 means A above B.
    always_comb begin
        if ((zero_a && zero_b) || (mag_eq && sign_a == sign_b))
            ord = 2'sd0;
        else if (sign_a != sign_b)
            ord = sign_a ? 2'sd1 : -2'sd1;
        else if (!sign_a)
            ord = mag_lt ? 2'sd1 : -2'sd1;
        else
            ord = mag_lt ? -2'sd1 : 2'sd1;
    end

    // Map to the condition-code encoding.
    always_comb begin
        if (nan_a || nan_b)
            rel = REL_UN;
        else if (ord == 2'sd0)
            rel = REL_EQ;
        else if (ord == 2'sd1)
            rel = REL_LT;
        else
            rel = REL_GT;
    end

endmodule

// File: rtl/qcmp_fcc_write.sv
// Module: builds the next status word. Writes the relation into the selected
// condition-code field and clears the trap-type field, or, for an illegal
// register, writes the bad-register code and leaves the fields unchanged.
module qcmp_fcc_write
    import qcmp_pkg::*;
#(
    parameter int STAT_W = 64
) (
    input  logic [STAT_W-1:0] status_in,
    input  logic [1:0]        fcc_sel,
    input  rel_e              rel,
    input  logic              illegal,
    output logic [STAT_W-1:0] status_next
);

    // Merge the relation or the error code into the status word.
    always_comb begin
        status_next = status_in;
        if (illegal) begin
            status_next[FTT_LSB +: FTT_W] = FTT_BAD_REG;
        end else begin
            status_next[FTT_LSB +: FTT_W] = '0;
            for (int i = 0; i < NUM_FCC; i++) begin
                if (fcc_sel == 2'(i))
                    status_next[fcc_lsb(i) +: 2] = rel;
            end
        end
    end

endmodule

// File: rtl/qcmp_unit.sv
// Module: top of the quad compare block. Classifies both operands, relates
// them, decides the invalid flag by mode, merges the result into the status
// word and registers everything so it is valid with done one cycle after
// start. Assumes start is a single-cycle pulse per request.
module qcmp_unit
    import qcmp_pkg::*;
#(
    parameter int EXP_W    = qcmp_pkg::EXP_W,
    parameter int FRAC_W   = qcmp_pkg::FRAC_W,
    parameter int STAT_W   = qcmp_pkg::STAT_W,
    parameter int REGNUM_W = qcmp_pkg::REGNUM_W,
    localparam int W       = 1 + EXP_W + FRAC_W,
    localparam int MAG_W   = W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                signaling,
    input  logic [1:0]          fcc_sel,
    input  logic [REGNUM_W-1:0] src_a_num,
    input  logic [REGNUM_W-1:0] src_b_num,
    input  logic [W-1:0]        op_a,
    input  logic [W-1:0]        op_b,
    input  logic [STAT_W-1:0]   status_in,
    output logic [STAT_W-1:0]   status_out,
    output logic [EXC_W-1:0]    exc_flags,
    output logic                done
);

    logic [1:0][W-1:0]     ops;
    logic [1:0]            nan_v;
    logic [1:0]            snan_v;
    logic [1:0]            zero_v;
    logic [1:0]            sign_v;
    logic [1:0][MAG_W-1:0] mag_v;
    rel_e                  rel;
    logic                  illegal;
    logic                  invalid;
    logic [STAT_W-1:0]     status_next;

    assign ops = {op_b, op_a};

    // One classifier per operand (index 0 = A, 1 = B).
    for (genvar g = 0; g < 2; g++) begin : g_cls
        qcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op      (ops[g]),
            .is_nan  (nan_v[g]),
            .is_snan (snan_v[g]),
            .is_zero (zero_v[g]),
            .sign    (sign_v[g]),
            .mag     (mag_v[g])
        );
    end

    qcmp_relate #(.MAG_W(MAG_W)) u_rel (
        .nan_a  (nan_v[0]),
        .nan_b  (nan_v[1]),
        .zero_a (zero_v[0]),
        .zero_b (zero_v[1]),
        .sign_a (sign_v[0]),
        .sign_b (sign_v[1]),
        .mag_a  (mag_v[0]),
        .mag_b  (mag_v[1]),
        .rel    (rel)
    );

    // A quad register number with bit 1 set is not a legal quad source.
    always_comb begin
        illegal = src_a_num[1] | src_b_num[1];
    end

    // Invalid rule: any unordered in signaling mode, signaling NaN otherwise.
    always_comb begin
        invalid = !illegal && (rel == REL_UN) && (signaling || (|snan_v));
    end

    qcmp_fcc_write #(.STAT_W(STAT_W)) u_wr (
        .status_in   (status_in),
        .fcc_sel     (fcc_sel),
        .rel         (rel),
        .illegal     (illegal),
        .status_next (status_next)
    );

    // Result registers: capture on start, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_out <= '0;
            exc_flags  <= '0;
            done       <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                status_out         <= status_next;
                exc_flags          <= '0;
                exc_flags[EXC_INV] <= invalid;
            end
        end
    end

endmodule

// File: rtl/qcmp_unit_chk.sv
// Module: property checker for qcmp_unit, attached with bind. Observes ports
// only and checks handshake timing, flag rules and status-field isolation.
module qcmp_unit_chk
    import qcmp_pkg::*;
#(
    parameter int STAT_W   = qcmp_pkg::STAT_W,
    parameter int REGNUM_W = qcmp_pkg::REGNUM_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                signaling,
    input logic [1:0]          fcc_sel,
    input logic [REGNUM_W-1:0] src_a_num,
    input logic [REGNUM_W-1:0] src_b_num,
    input logic [STAT_W-1:0]   status_in,
    input logic [STAT_W-1:0]   status_out,
    input logic [EXC_W-1:0]    exc_flags,
    input logic                done
);

    // Read the condition-code field picked by sel.
    function automatic logic [1:0] get_fcc(input logic [STAT_W-1:0] st,
                                           input logic [1:0] sel);
        return st[fcc_lsb(int'(sel)) +: 2];
    endfunction

    // Mask of the bits a legal compare must leave alone.
    function automatic logic [STAT_W-1:0] keep_mask(input logic [1:0] sel);
        logic [STAT_W-1:0] m;
        m = '1;
        m[FTT_LSB +: FTT_W] = '0;
        m[fcc_lsb(int'(sel)) +: 2] = 2'b00;
        return m;
    endfunction

    logic illegal_now;
    assign illegal_now = src_a_num[1] | src_b_num[1];

    a_r1_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r1_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(status_out) && $stable(exc_flags)));

    a_r5_signaling_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        (start && signaling && !illegal_now) |=>
            ((get_fcc(status_out, $past(fcc_sel)) == 2'd3) == exc_flags[EXC_INV]));

    a_r6_invalid_only_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !illegal_now) |=>
            (!exc_flags[EXC_INV] || get_fcc(status_out, $past(fcc_sel)) == 2'd3));

    a_r5_other_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (exc_flags[EXC_INV-1:0] == '0));

    a_r7_r8_field_isolation: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !illegal_now) |=>
            (((status_out & keep_mask($past(fcc_sel))) ==
              ($past(status_in) & keep_mask($past(fcc_sel)))) &&
             (status_out[FTT_LSB +: FTT_W] == '0)));

    a_r9_illegal_register: assert property (@(posedge clk) disable iff (!rst_n)
        (start && illegal_now) |=>
            ((status_out[FTT_LSB +: FTT_W] == FTT_BAD_REG) &&
             (exc_flags == '0) &&
             ((status_out & ~(STAT_W'(7) << FTT_LSB)) ==
              ($past(status_in) & ~(STAT_W'(7) << FTT_LSB)))));

endmodule

bind qcmp_unit qcmp_unit_chk #(.STAT_W(STAT_W), .REGNUM_W(REGNUM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .signaling  (signaling),
    .fcc_sel    (fcc_sel),
    .src_a_num  (src_a_num),
    .src_b_num  (src_b_num),
    .status_in  (status_in),
    .status_out (status_out),
    .exc_flags  (exc_flags),
    .done       (done)
);

// File: tb/qcmp_unit_test.sv
`timescale 1ns/1ps
// Directed bench for qcmp_unit: one task per scenario, each checking itself.
module qcmp_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signaling = 1'b0;
    logic [1:0]   fcc_sel = 2'd0;
    logic [4:0]   src_a_num = 5'd0;
    logic [4:0]   src_b_num = 5'd4;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic [63:0]  status_in = '0;
    logic [63:0]  status_out;
    logic [4:0]   exc_flags;
    logic         done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    localparam logic [127:0] P_ONE  = {16'h3FFF, 112'h0};
    localparam logic [127:0] P_TWO  = {16'h4000, 112'h0};
    localparam logic [127:0] N_ONE  = {16'hBFFF, 112'h0};
    localparam logic [127:0] N_TWO  = {16'hC000, 112'h0};
    localparam logic [127:0] P_ZERO = 128'h0;
    localparam logic [127:0] N_ZERO = {1'b1, 127'h0};
    localparam logic [127:0] P_INF  = {16'h7FFF, 112'h0};
    localparam logic [127:0] Q_NAN  = {16'h7FFF, 1'b1, 111'h0};
    localparam logic [127:0] S_NAN  = {16'h7FFF, 1'b0, 111'h1};

    always #2 clk = ~clk;

    qcmp_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .signaling  (signaling),
        .fcc_sel    (fcc_sel),
        .src_a_num  (src_a_num),
        .src_b_num  (src_b_num),
        .op_a       (op_a),
        .op_b       (op_b),
        .status_in  (status_in),
        .status_out (status_out),
        .exc_flags  (exc_flags),
        .done       (done)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected status word for a legal compare, from R7 and R8.
    function automatic logic [63:0] exp_stat(input logic [63:0] st,
                                             input logic [1:0] sel,
                                             input logic [1:0] rel);
        logic [63:0] r;
        r = st;
        r[16:14] = 3'd0;
        case (sel)
            2'd0: r[11:10] = rel;
            2'd1: r[33:32] = rel;
            2'd2: r[35:34] = rel;
            default: r[37:36] = rel;
        endcase
        return r;
    endfunction

    // Issue one compare; outputs are sampled at the following falling edge.
    task automatic run(input logic [127:0] a, input logic [127:0] b,
                       input logic sig, input logic [1:0] sel,
                       input logic [63:0] st);
        @(negedge clk);
        op_a = a; op_b = b; signaling = sig; fcc_sel = sel; status_in = st;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic cmp_case(input string req, input logic [127:0] a,
                            input logic [127:0] b, input logic sig,
                            input logic [1:0] exp_rel, input logic exp_inv);
        run(a, b, sig, 2'd0, 64'h0);
        chk(req, "done", 64'(done), 64'd1);
        chk(req, "status", status_out, exp_stat(64'h0, 2'd0, exp_rel));
        chk(req, "flags", 64'(exc_flags), 64'({exp_inv, 4'b0000}));
    endtask

    task automatic t_reset;
        chk("R10", "status_out", status_out, 64'h0);
        chk("R10", "exc_flags", 64'(exc_flags), 64'h0);
        chk("R10", "done", 64'(done), 64'h0);
    endtask

    task automatic t_order;
        cmp_case("R2", P_ONE, P_TWO, 1'b0, 2'd1, 1'b0);
        cmp_case("R2", P_TWO, P_ONE, 1'b0, 2'd2, 1'b0);
        cmp_case("R2", P_TWO, P_TWO, 1'b1, 2'd0, 1'b0);
        cmp_case("R2", N_ONE, P_ONE, 1'b0, 2'd1, 1'b0);
        cmp_case("R2", N_ONE, N_TWO, 1'b0, 2'd2, 1'b0);
        cmp_case("R2", N_TWO, N_ONE, 1'b0, 2'd1, 1'b0);
        cmp_case("R2", P_INF, P_TWO, 1'b0, 2'd2, 1'b0);
    endtask

    task automatic t_zero;
        cmp_case("R3", P_ZERO, N_ZERO, 1'b0, 2'd0, 1'b0);
        cmp_case("R3", N_ZERO, P_ZERO, 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_nan;
        cmp_case("R4", Q_NAN, P_ONE, 1'b0, 2'd3, 1'b0);
        cmp_case("R6", P_ONE, Q_NAN, 1'b0, 2'd3, 1'b0);
        cmp_case("R5", Q_NAN, P_ONE, 1'b1, 2'd3, 1'b1);
        cmp_case("R6", S_NAN, P_ONE, 1'b0, 2'd3, 1'b1);
        cmp_case("R6", P_TWO, S_NAN, 1'b0, 2'd3, 1'b1);
    endtask

    task automatic t_fields;
        for (int s = 0; s < 4; s++) begin
            run(P_TWO, P_ONE, 1'b0, 2'(s), 64'hFFFF_FFFF_FFFF_FFFF);
            chk("R7", "field select",
                status_out, exp_stat(64'hFFFF_FFFF_FFFF_FFFF, 2'(s), 2'd2));
        end
        run(P_ONE, P_ONE, 1'b0, 2'd0, 64'h0001_C000);
        chk("R8", "trap type cleared", status_out, 64'h0000_0000);
    endtask

    task automatic t_illegal;
        src_a_num = 5'd2;
        run(Q_NAN, P_ONE, 1'b1, 2'd1, 64'h0000_0030_0000_0C00);
        chk("R9", "bad rs1 status", status_out, 64'h0000_0030_0001_8C00);
        chk("R9", "bad rs1 flags", 64'(exc_flags), 64'h0);
        src_a_num = 5'd0;
        src_b_num = 5'd6;
        run(P_ONE, P_TWO, 1'b0, 2'd0, 64'h0);
        chk("R9", "bad rs2 status", status_out, 64'h0000_0000_0001_8000);
        src_b_num = 5'd4;
    endtask

    task automatic t_hold;
        run(Q_NAN, P_ONE, 1'b1, 2'd2, 64'h0);
        status_in = 64'h1234_5678_9ABC_DEF0;
        op_a = P_ONE;
        @(negedge clk);
        chk("R1", "done single pulse", 64'(done), 64'd0);
        chk("R1", "status held", status_out, exp_stat(64'h0, 2'd2, 2'd3));
        chk("R1", "flags held", 64'(exc_flags), 64'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_order();
        t_zero();
        t_nan();
        t_fields();
        t_illegal();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule